// File: doc/BRIEF.md
# Overlay Alpha Blending Mixer

The mixer combines a main 4:2:2 YCbCr video stream with an overlay stream of the same format, one 8-bit component per clock, in the sample order Cb, Y, Cr, Y. Each output component is a weighted sum of the video and overlay components. The weight is a 4-bit value with sixteen steps, running from no overlay to full overlay. The top code is a special case: at that code the overlay component passes through untouched.

The main video comes from one of two input ports, chosen by a select input. The weight has four possible sources. It can be forced to zero in a video-only pass mode. It can be a fixed table entry. It can be read from a four-entry programmable table indexed by a 1-bit or 2-bit alpha code. It can also be taken directly from a 4-bit alpha input. A two-bit phase counter, cleared by a start-of-line strobe, tracks the position in the Cb, Y, Cr, Y cycle. A weight taken on a Cb sample covers the whole co-sited Cb/Y/Cr group. The lone Y sample that follows the group takes a weight of its own.

The table is loaded through a simple write port. The blended result is registered, so it appears one clock after its input, together with a valid flag.

Top module: `ovl_blend_mixer`

## Requirements
- R1: While reset is asserted, `out_vld` and `out_dat` are 0 and all four table entries are 0. After reset, every table-based mode therefore blends with weight 0 until the table is loaded.
- R2: A sample presented with `in_vld`=1 produces its result on `out_dat`, with `out_vld`=1, one clock later. A clock with `in_vld`=0 gives `out_vld`=0 on the next clock and leaves `out_dat` unchanged.
- R3: For a weight w in 0..14, the output is (V·(16−w) + O·w + 8) >> 4, where V is the video component and O is the overlay component.
- R4: For weight 15 (4'b1111), the output equals the overlay component exactly.
- R5: `vid_sel`=0 takes the video from `pri_dat`, and `vid_sel`=1 takes it from `sec_dat`.
- R6: With `amode`=2'b00 and `pass_only`=1, the output equals the selected video component. The alpha input and the table contents have no effect in this mode.
- R7: With `amode`=2'b00 and `pass_only`=0, the weight is table entry 0 and the alpha input is ignored.
- R8: With `amode`=2'b01, the weight is table entry `alpha_in[0]`. Bits `alpha_in[3:1]` are ignored.
- R9: With `amode`=2'b10, the weight is table entry `alpha_in[1:0]`.
- R10: With `amode`=2'b11, the weight is `alpha_in` itself.
- R11: The phase counter only advances on valid samples. It is cleared to 0 (Cb) by a valid sample with `sol`=1, and otherwise counts 0,1,2,3 (Cb, Y0, Cr, Y1) and wraps. A weight is taken from the current alpha and mode on phases 0 and 3. Phase 0's weight is also used on phases 1 and 2, where the alpha input is ignored.
- R12: A write with `tbl_we`=1 stores `tbl_wdata` at entry `tbl_addr`, and the new value takes effect from the next clock. A sample blended in the same clock as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample valid |
| sol | input | 1 | Start of line; marks a Cb sample |
| pri_dat | input | 8 | Primary video port component |
| sec_dat | input | 8 | Secondary video port component |
| osd_dat | input | 8 | Overlay component |
| alpha_in | input | 4 | Alpha code or direct weight |
| vid_sel | input | 1 | Video port select (0 primary, 1 secondary) |
| amode | input | 2 | Alpha source mode |
| pass_only | input | 1 | Video-only pass when amode is 00 |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 2 | Table write address |
| tbl_wdata | input | 4 | Table write data |
| out_dat | output | 8 | Blended component |
| out_vld | output | 1 | Output valid |

## Verification
The blend arithmetic is tested at its extremes: weight 0 against video, weight 15 against overlay, and weights 1 and 8, whose results depend on the +8 rounding term. That shows whether the rounding and the unmixed top code are handled. Each mode is run with alpha bits set that the mode must ignore, so any leak of those bits into the table address or the weight shows up. Lines vary the alpha on every sample, so holding the weight across the group, re-sampling it on the lone Y, and resetting the phase on a start-of-line mid-group each give different outputs from a per-sample weight. A table write that lands on the same clock as a blend using that entry tells whether the read sees the old or the new value.

// File: rtl/ovl_mix_pkg.sv
package ovl_mix_pkg;

  typedef enum logic [1:0] {
    AM_FIXED  = 2'b00,
    AM_CODE1  = 2'b01,
    AM_CODE2  = 2'b10,
    AM_DIRECT = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;

endpackage

// File: rtl/ovl_alpha_lut.sv
module ovl_alpha_lut #(
  parameter int WW      = 4,
  parameter int ENTRIES = 4,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [WW-1:0] rd_data
);

  logic [ENTRIES-1:0][WW-1:0] ent_q;
  logic [ENTRIES-1:0][WW-1:0] ent_d;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(gi));

    always_comb begin
      ent_d[gi] = ent_q[gi];
      if (hit) ent_d[gi] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[gi] <= '0;
      else if (hit) ent_q[gi] <= ent_d[gi];
    end
  end

  assign rd_data = ent_q[rd_addr];

  // R12
  lut_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/ovl_weight_sel.sv
module ovl_weight_sel
  import ovl_mix_pkg::*;
#(
  parameter int WW = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          sol,
  input  logic [1:0]    amode,
  input  logic          pass_only,
  input  logic [WW-1:0] alpha_in,
  input  logic [WW-1:0] lut_data,
  output logic [AW-1:0] lut_addr,
  output logic [WW-1:0] weight
);

  phase_e        phase_q, phase_d, cur_ph;
  logic [WW-1:0] hold_q, hold_d;
  logic [WW-1:0] new_w;
  logic          take;
  logic          bypass;
  amode_e        mode;

  assign mode   = amode_e'(amode);
  assign bypass = (mode == AM_FIXED) && pass_only;

  always_comb begin
    cur_ph = sol ? PH_CB : phase_q;
    take   = smp_vld && ((cur_ph == PH_CB) || (cur_ph == PH_Y1));
  end

  always_comb begin
    unique case (mode)
      AM_CODE1:  lut_addr = AW'(alpha_in[0]);
      AM_CODE2:  lut_addr = alpha_in[AW-1:0];
      default:   lut_addr = '0;
    endcase
  end

  always_comb begin
    unique case (mode)
      AM_FIXED:  new_w = pass_only ? '0 : lut_data;
      AM_DIRECT: new_w = alpha_in;
      default:   new_w = lut_data;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    hold_d  = hold_q;
    if (smp_vld) phase_d = phase_e'(cur_ph + 2'd1);
    if (take)    hold_d  = new_w;
  end

  always_comb begin
    if (bypass)    weight = '0;
    else if (take) weight = new_w;
    else           weight = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CB;
      hold_q  <= '0;
    end else begin
      if (smp_vld) phase_q <= phase_d;
      if (take)    hold_q  <= hold_d;
    end
  end

  // R11
  sol_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && sol) |=> phase_q == PH_Y0);

  // R11
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (phase_q == $past(phase_q)) && (hold_q == $past(hold_q)));

endmodule

// File: rtl/ovl_blend_core.sv
module ovl_blend_core #(
  parameter int DW = 8,
  parameter int WW = 4
) (
  input  logic [DW-1:0] vid,
  input  logic [DW-1:0] ovl,
  input  logic [WW-1:0] weight,
  output logic [DW-1:0] mix
);

  localparam int SW = DW + WW + 1;
  localparam logic [WW:0]   ONE  = (WW+1)'(1) << WW;
  localparam logic [WW-1:0] FULL = '1;
  localparam logic [SW-1:0] HALF = SW'(1) << (WW - 1);

  logic [WW:0]   inv_w;
  logic [SW-1:0] v_term, o_term, sum;

  always_comb begin
    inv_w  = ONE - {1'b0, weight};
    v_term = SW'(vid) * SW'(inv_w);
    o_term = SW'(ovl) * SW'(weight);
    sum    = v_term + o_term + HALF;
    mix    = (weight == FULL) ? ovl : sum[WW +: DW];
  end

  // R3
  always_comb begin
    if (!$isunknown({vid, ovl, weight}) && weight != FULL) begin
      mix_range_chk: assert ((mix >= ((vid < ovl) ? vid : ovl)) &&
                             (mix <= ((vid > ovl) ? vid : ovl)));
    end
  end

endmodule

// File: rtl/ovl_blend_mixer.sv
module ovl_blend_mixer #(
  parameter int DW      = 8,
  parameter int WW      = 4,
  parameter int ENTRIES = 4,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          sol,
  input  logic [DW-1:0] pri_dat,
  input  logic [DW-1:0] sec_dat,
  input  logic [DW-1:0] osd_dat,
  input  logic [WW-1:0] alpha_in,
  input  logic          vid_sel,
  input  logic [1:0]    amode,
  input  logic          pass_only,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [WW-1:0] tbl_wdata,
  output logic [DW-1:0] out_dat,
  output logic          out_vld
);

  logic [DW-1:0] video;
  logic [AW-1:0] lut_addr;
  logic [WW-1:0] lut_data;
  logic [WW-1:0] weight;
  logic [DW-1:0] mix;
  logic [DW-1:0] dat_q, dat_d;
  logic          vld_q, vld_d;

  assign video = vid_sel ? sec_dat : pri_dat;

  ovl_alpha_lut #(.WW(WW), .ENTRIES(ENTRIES)) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_addr (lut_addr),
    .rd_data (lut_data)
  );

  ovl_weight_sel #(.WW(WW), .AW(AW)) u_wsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (in_vld),
    .sol       (sol),
    .amode     (amode),
    .pass_only (pass_only),
    .alpha_in  (alpha_in),
    .lut_data  (lut_data),
    .lut_addr  (lut_addr),
    .weight    (weight)
  );

  ovl_blend_core #(.DW(DW), .WW(WW)) u_core (
    .vid    (video),
    .ovl    (osd_dat),
    .weight (weight),
    .mix    (mix)
  );

  always_comb begin
    vld_d = in_vld;
    dat_d = in_vld ? mix : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_vld) dat_q <= dat_d;
    end
  end

  assign out_dat = dat_q;
  assign out_vld = vld_q;

  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld && $stable(out_dat));

  // R6
  pass_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && amode == 2'b00 && pass_only) |=> out_dat == $past(video));

endmodule

// File: tb/tb_ovl_blend_mixer.sv
module tb_ovl_blend_mixer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld, sol, vid_sel, pass_only, tbl_we;
  logic [7:0] pri_dat, sec_dat, osd_dat;
  logic [3:0] alpha_in, tbl_wdata;
  logic [1:0] amode, tbl_addr;
  logic [7:0] out_dat;
  logic       out_vld;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  ovl_blend_mixer dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .sol(sol),
    .pri_dat(pri_dat), .sec_dat(sec_dat), .osd_dat(osd_dat),
    .alpha_in(alpha_in), .vid_sel(vid_sel), .amode(amode),
    .pass_only(pass_only), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .out_dat(out_dat), .out_vld(out_vld)
  );

  function automatic logic [7:0] ref_mix(input int v, input int o, input int w);
    if (w == 15) return 8'(o);
    return 8'((v * (16 - w) + o * w + 8) >> 4);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at posedge, sampled at next negedge
  task automatic smp(input bit s, input logic [7:0] v, input logic [7:0] o,
                     input logic [3:0] a, input logic [7:0] exp, input string req);
    in_vld   = 1'b1;
    sol      = s;
    pri_dat  = vid_sel ? (v ^ 8'h5A) : v;
    sec_dat  = vid_sel ? v : (v ^ 8'h5A);
    osd_dat  = o;
    alpha_in = a;
    @(posedge clk);
    @(negedge clk);
    in_vld = 1'b0;
    sol    = 1'b0;
    check({req, " valid"}, int'(out_vld), 1);
    check(req, int'(out_dat), int'(exp));
  endtask

  task automatic wr(input logic [1:0] ad, input logic [3:0] d);
    tbl_we = 1'b1; tbl_addr = ad; tbl_wdata = d;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 out_vld in reset", int'(out_vld), 0);
    check("R1 out_dat in reset", int'(out_dat), 0);
  endtask

  task automatic t_table_zero;
    amode = 2'b10; pass_only = 1'b0; vid_sel = 1'b0;
    smp(1, 8'd100, 8'd200, 4'd3, 8'd100, "R1 table reset zero");
    smp(0, 8'd40,  8'd250, 4'd2, 8'd40,  "R1 table reset zero Y0");
  endtask

  task automatic t_code2;
    amode = 2'b10;
    smp(1, 8'd100, 8'd200, 4'd1, ref_mix(100, 200, 9),  "R9 Cb entry1");
    smp(0, 8'd50,  8'd10,  4'd2, ref_mix(50, 10, 9),    "R11 Y0 holds group weight");
    smp(0, 8'd90,  8'd30,  4'd3, ref_mix(90, 30, 9),    "R11 Cr holds group weight");
    smp(0, 8'd70,  8'd123, 4'd2, 8'd123,                "R11 Y1 new weight, R4 code 15");
    smp(0, 8'd80,  8'd160, 4'd3, ref_mix(80, 160, 6),   "R9 wrap to Cb entry3");
  endtask

  task automatic t_code1;
    amode = 2'b01;
    smp(1, 8'd200, 8'd0, 4'b1110, ref_mix(200, 0, 3), "R8 upper bits ignored entry0");
    smp(1, 8'd200, 8'd0, 4'b0001, ref_mix(200, 0, 9), "R8 entry1");
  endtask

  task automatic t_direct;
    amode = 2'b11;
    smp(1, 8'd200, 8'd37,  4'd15, 8'd37,  "R4 R10 full overlay");
    smp(1, 8'd200, 8'd37,  4'd0,  8'd200, "R10 zero weight video");
    smp(1, 8'd0,   8'd255, 4'd1,  8'd16,  "R3 rounding w1");
    smp(1, 8'd255, 8'd0,   4'd1,  8'd239, "R3 rounding w1 video");
    smp(1, 8'd100, 8'd201, 4'd8,  8'd151, "R3 half weight");
    smp(1, 8'd255, 8'd255, 4'd14, 8'd255, "R3 no overflow");
  endtask

  task automatic t_pass;
    amode = 2'b00; pass_only = 1'b1; vid_sel = 1'b1;
    smp(1, 8'd20, 8'd250, 4'd15, 8'd20, "R6 R5 pass secondary");
    vid_sel = 1'b0;
    smp(0, 8'd10, 8'd250, 4'd15, 8'd10, "R6 R5 pass primary");
    pass_only = 1'b0;
  endtask

  task automatic t_fixed;
    amode = 2'b00; pass_only = 1'b0;
    smp(1, 8'd160, 8'd0, 4'd15, 8'd130, "R7 fixed entry0");
    smp(0, 8'd160, 8'd0, 4'd9,  8'd130, "R7 alpha ignored");
  endtask

  task automatic t_sol;
    amode = 2'b11;
    smp(1, 8'd0, 8'd160, 4'd2,  ref_mix(0, 160, 2),  "R11 sol Cb");
    smp(0, 8'd0, 8'd160, 4'd5,  ref_mix(0, 160, 2),  "R11 Y0 ignores alpha");
    smp(1, 8'd0, 8'd160, 4'd12, ref_mix(0, 160, 12), "R11 mid-group sol resync");
  endtask

  task automatic t_idle;
    amode = 2'b11;
    smp(1, 8'd0, 8'd64, 4'd4, ref_mix(0, 64, 4), "R2 before idle");
    @(posedge clk);
    @(negedge clk);
    check("R2 idle out_vld low", int'(out_vld), 0);
    check("R2 idle out_dat held", int'(out_dat), int'(ref_mix(0, 64, 4)));
    smp(0, 8'd0, 8'd128, 4'd9, ref_mix(0, 128, 4), "R11 idle does not advance phase");
  endtask

  task automatic t_wr_same;
    amode = 2'b10;
    tbl_we = 1'b1; tbl_addr = 2'd2; tbl_wdata = 4'd1;
    smp(1, 8'd30, 8'd99, 4'd2, 8'd99, "R12 same-cycle write uses old entry");
    tbl_we = 1'b0;
    smp(1, 8'd0, 8'd255, 4'd2, 8'd16, "R12 new entry next sample");
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; sol = 1'b0; vid_sel = 1'b0; pass_only = 1'b0;
    tbl_we = 1'b0; pri_dat = '0; sec_dat = '0; osd_dat = '0; alpha_in = '0;
    amode = 2'b00; tbl_addr = '0; tbl_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_table_zero();
    wr(2'd0, 4'd3);
    wr(2'd1, 4'd9);
    wr(2'd2, 4'd15);
    wr(2'd3, 4'd6);
    t_code2();
    t_code1();
    t_direct();
    t_pass();
    t_fixed();
    t_sol();
    t_idle();
    t_wr_same();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule